// File: doc/BRIEF.md
# Banked Program Counter with Deferred Bank Select

This block holds the 12-bit program counter of a small 8-bit controller whose 4K-word program space is split into two 2K banks. Bit 11 of the counter names the bank. Sequential fetch advances only the low eleven bits, so straight-line code never leaves its bank. A separate bank flip-flop is written by two select strobes, one for the upper bank (opcode 73h) and one for the lower bank (opcode 63h). Its value reaches bit 11 only when a jump or call is taken, so the select can be issued well before the branch that uses it.

An eight-entry return stack holds full 12-bit addresses. A call can therefore enter a subroutine in the other bank, and the matching return lands back in the caller's bank. The return does not touch the bank flip-flop. An interrupt request vectors the counter to address 3 or 7 in the lower bank and sets an in-service flag. While that flag is set, every address loaded into the counter has bit 11 forced to 0. Bank selects made during service still write the flip-flop. The return-from-interrupt strobe restores the saved 12-bit address and clears the flag.

The strobes come from an instruction decoder outside this block. When several arrive in the same cycle, a fixed priority picks a single program-counter action. A bank select is applied alongside that action.

Top module: `banked_pc`

## Requirements
- R1: While rst is high, and in the cycle after it, pc_o is 0x000, bank_o is 0 and in_isr_o is 0.
- R2: A step with no higher-priority strobe sets pc_o[10:0] to (pc_o[10:0]+1) mod 2048 and leaves pc_o[11] unchanged. From 0x7FF it goes to 0x000, and from 0xFFF it goes to 0x800.
- R3: sel_hi_i alone sets bank_o to 1, and sel_lo_i alone clears it. When both are high, bank_o holds. A bank select with no other strobe leaves pc_o unchanged.
- R4: A jump outside service loads pc_o with {bank_o, target_i}. It uses the value bank_o had before a bank select in the same cycle.
- R5: A call loads pc_o the way a jump does. It also pushes {pc_o[11], (pc_o[10:0]+1) mod 2048}, the 12-bit return address.
- R6: A return pops a 12-bit address into pc_o. It changes neither bank_o nor in_isr_o.
- R7: An interrupt pushes the current pc_o and sets in_isr_o to 1. It loads pc_o with 0x003 when irq_vec_i is 0 and with 0x007 when irq_vec_i is 1.
- R8: While in_isr_o is 1, pc_o[11] stays 0 through jumps, calls, returns and steps. Bank selects still update bank_o.
- R9: A return-from-interrupt pops the full 12-bit address into pc_o, bit 11 included, and clears in_isr_o.
- R10: The stack is 8 deep. A ninth push overwrites the oldest entry. A pop from an empty stack returns the entry the wrapped pointer addresses, so after 9 calls with returns A1..A9, 9 returns give A9, A8, ..., A2, A9.
- R11: The program-counter action follows the priority interrupt > return-from-interrupt > return > call > jump > step. With none of these strobes, pc_o holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Sequential fetch strobe |
| sel_lo_i | input | 1 | Select lower bank (opcode 63h) |
| sel_hi_i | input | 1 | Select upper bank (opcode 73h) |
| jump_i | input | 1 | Jump taken |
| call_i | input | 1 | Call taken |
| target_i | input | 11 | In-bank branch target |
| ret_i | input | 1 | Plain return |
| retr_i | input | 1 | Return from interrupt |
| irq_i | input | 1 | Interrupt accepted |
| irq_vec_i | input | 1 | Vector choice: 0 gives address 3, 1 gives address 7 |
| pc_o | output | 12 | Current program counter |
| bank_o | output | 1 | Bank flip-flop state |
| in_isr_o | output | 1 | Interrupt service in progress |

## Verification
A bank select and a branch can arrive in the same cycle. The bench drives a lower-bank select together with a jump while the flip-flop is set. It expects the jump to land in the upper bank and the flip-flop to read 0 one cycle later. The bench also raises an interrupt together with a step and a jump, and then a call together with a jump. In each case it expects only the higher-priority action to affect the counter and the stack, which the later returns confirm.

// File: rtl/banked_pc_pkg.sv
package banked_pc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETR = 3'd5,
    OP_IRQ  = 3'd6
  } pc_op_e;
endpackage

// File: rtl/pc_op_decode.sv
module pc_op_decode
  import banked_pc_pkg::*;
(
  input  logic   step,
  input  logic   jump,
  input  logic   call,
  input  logic   ret,
  input  logic   retr,
  input  logic   irq,
  output pc_op_e op,
  output logic   push,
  output logic   pop
);
  always_comb begin
    if (irq)       op = OP_IRQ;
    else if (retr) op = OP_RETR;
    else if (ret)  op = OP_RET;
    else if (call) op = OP_CALL;
    else if (jump) op = OP_JUMP;
    else if (step) op = OP_STEP;
    else           op = OP_HOLD;
  end

  always_comb begin
    push = (op == OP_IRQ) || (op == OP_CALL);
    pop  = (op == OP_RET) || (op == OP_RETR);
  end
endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg (
  input  logic clk,
  input  logic rst,
  input  logic sel_lo,
  input  logic sel_hi,
  output logic bank_q
);
  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else if (sel_hi && !sel_lo) bank_q <= 1'b1;
    else if (sel_lo && !sel_hi) bank_q <= 1'b0;
  end

  // R3: the upper select alone sets the flip-flop
  assert_hi_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_hi && !sel_lo) |=> bank_q);
  // R3: both selects together leave it alone
  assert_both_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_hi && sel_lo) |=> $stable(bank_q));
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] pop_data
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_dec;

  assign sp_dec   = sp_q - 1'b1;
  assign pop_data = mem[sp_dec];

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + 1'b1;
    else if (pop)  sp_q <= sp_dec;
  end

  // R11: the decoder never asks for push and pop at once
  assert_push_pop_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
  // R10: a pop followed by a push leaves the pointer where it started
  assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (push |=> sp_q == $past(sp_q, 2)));
endmodule

// File: rtl/banked_pc.sv
module banked_pc
  import banked_pc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STACK_DEPTH = 8,
  parameter int VEC_A       = 3,
  parameter int VEC_B       = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_i,
  input  logic                sel_lo_i,
  input  logic                sel_hi_i,
  input  logic                jump_i,
  input  logic                call_i,
  input  logic [ADDR_W-2:0]   target_i,
  input  logic                ret_i,
  input  logic                retr_i,
  input  logic                irq_i,
  input  logic                irq_vec_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic                bank_o,
  output logic                in_isr_o
);
  localparam int OFF_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] VEC_ADDR_A = ADDR_W'(VEC_A);
  localparam logic [ADDR_W-1:0] VEC_ADDR_B = ADDR_W'(VEC_B);

  pc_op_e            op;
  logic              push, pop;
  logic [ADDR_W-1:0] pc_q, pc_d, push_data, pop_data;
  logic [OFF_W-1:0]  off_inc;
  logic              bank_q, isr_q, isr_d, load_bit;

  pc_op_decode u_dec (
    .step(step_i), .jump(jump_i), .call(call_i), .ret(ret_i),
    .retr(retr_i), .irq(irq_i), .op(op), .push(push), .pop(pop)
  );

  bank_sel_reg u_bank (
    .clk(clk), .rst(rst), .sel_lo(sel_lo_i), .sel_hi(sel_hi_i), .bank_q(bank_q)
  );

  ret_stack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_data(push_data), .pop_data(pop_data)
  );

  assign off_inc  = pc_q[OFF_W-1:0] + 1'b1;
  assign load_bit = isr_q ? 1'b0 : bank_q;

  always_comb begin
    push_data = (op == OP_IRQ) ? pc_q : {pc_q[ADDR_W-1], off_inc};
  end

  always_comb begin
    pc_d  = pc_q;
    isr_d = isr_q;
    case (op)
      OP_IRQ: begin
        pc_d  = irq_vec_i ? VEC_ADDR_B : VEC_ADDR_A;
        isr_d = 1'b1;
      end
      OP_RETR: begin
        pc_d  = pop_data;
        isr_d = 1'b0;
      end
      OP_RET:  pc_d = {pop_data[ADDR_W-1] & ~isr_q, pop_data[OFF_W-1:0]};
      OP_CALL: pc_d = {load_bit, target_i};
      OP_JUMP: pc_d = {load_bit, target_i};
      OP_STEP: pc_d = {pc_q[ADDR_W-1], off_inc};
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      isr_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      isr_q <= isr_d;
    end
  end

  assign pc_o     = pc_q;
  assign bank_o   = bank_q;
  assign in_isr_o = isr_q;

  // R2: a step keeps the bank bit and advances the offset
  assert_step_keeps_bank_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !jump_i && !call_i && !ret_i && !retr_i && !irq_i) |=>
      (pc_q[ADDR_W-1] == $past(pc_q[ADDR_W-1]) &&
       pc_q[OFF_W-1:0] == $past(pc_q[OFF_W-1:0]) + OFF_W'(1)));
  // R3: a bank select by itself does not move the counter
  assert_sel_no_pc_R3: assert property (@(posedge clk) disable iff (rst)
    ((sel_lo_i || sel_hi_i) && !step_i && !jump_i && !call_i && !ret_i &&
     !retr_i && !irq_i) |=> $stable(pc_q));
  // R7: an interrupt lands on one of the two vectors with the flag set
  assert_irq_vector_R7: assert property (@(posedge clk) disable iff (rst)
    irq_i |=> (isr_q && (pc_q == VEC_ADDR_A || pc_q == VEC_ADDR_B)));
  // R8: bit 11 stays low for the whole service routine
  assert_isr_bank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    isr_q |-> !pc_q[ADDR_W-1]);
  // R6: a plain return leaves the flag alone
  assert_ret_keeps_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !retr_i && !irq_i) |=> (isr_q == $past(isr_q)));
endmodule

// File: tb/banked_pc_tb.sv
module banked_pc_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 0, sel_lo_i = 0, sel_hi_i = 0, jump_i = 0, call_i = 0;
  logic ret_i = 0, retr_i = 0, irq_i = 0, irq_vec_i = 0;
  logic [10:0] target_i = '0;
  logic [11:0] pc_o;
  logic bank_o, in_isr_o;

  int checks = 0;
  int fails  = 0;

  logic [11:0] m_pc;
  logic        m_bank, m_isr;
  logic [11:0] m_stk [8];
  int          m_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_pc u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .sel_lo_i(sel_lo_i),
    .sel_hi_i(sel_hi_i), .jump_i(jump_i), .call_i(call_i), .target_i(target_i),
    .ret_i(ret_i), .retr_i(retr_i), .irq_i(irq_i), .irq_vec_i(irq_vec_i),
    .pc_o(pc_o), .bank_o(bank_o), .in_isr_o(in_isr_o)
  );

  task automatic check_val(input string tag, input string what,
                           input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check_val(tag, "pc", pc_o, m_pc);
    check_val(tag, "bank", {11'd0, bank_o}, {11'd0, m_bank});
    check_val(tag, "isr", {11'd0, in_isr_o}, {11'd0, m_isr});
  endtask

  task automatic model_push(input logic [11:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  function automatic logic [11:0] model_pop();
    m_sp = (m_sp + 7) % 8;
    return m_stk[m_sp];
  endfunction

  // one cycle: drive after negedge, model update, compare at next negedge
  task automatic cyc(input string tag, input logic st, input logic s0,
                     input logic s1, input logic jp, input logic cl,
                     input logic [10:0] tg, input logic rt, input logic rr,
                     input logic iq, input logic vs);
    logic [11:0] p;
    step_i = st; sel_lo_i = s0; sel_hi_i = s1; jump_i = jp; call_i = cl;
    target_i = tg; ret_i = rt; retr_i = rr; irq_i = iq; irq_vec_i = vs;
    if (iq) begin
      model_push(m_pc); m_pc = vs ? 12'h007 : 12'h003; m_isr = 1'b1;
    end else if (rr) begin
      m_pc = model_pop(); m_isr = 1'b0;
    end else if (rt) begin
      p = model_pop(); m_pc = {p[11] & ~m_isr, p[10:0]};
    end else if (cl) begin
      model_push({m_pc[11], m_pc[10:0] + 11'd1});
      m_pc = {m_isr ? 1'b0 : m_bank, tg};
    end else if (jp) begin
      m_pc = {m_isr ? 1'b0 : m_bank, tg};
    end else if (st) begin
      m_pc = {m_pc[11], m_pc[10:0] + 11'd1};
    end
    if (s1 && !s0) m_bank = 1'b1;
    else if (s0 && !s1) m_bank = 1'b0;
    @(negedge clk);
    step_i = 0; sel_lo_i = 0; sel_hi_i = 0; jump_i = 0; call_i = 0;
    ret_i = 0; retr_i = 0; irq_i = 0;
    check_all(tag);
  endtask

  task automatic t_reset();
    m_pc = '0; m_bank = 0; m_isr = 0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_step();
    cyc("R2", 1,0,0,0,0,'0,0,0,0,0);
    cyc("R2", 1,0,0,0,0,'0,0,0,0,0);
    cyc("R4", 0,0,0,1,0,11'h7FE,0,0,0,0);
    cyc("R2", 1,0,0,0,0,'0,0,0,0,0);
    cyc("R2", 1,0,0,0,0,'0,0,0,0,0);  // 0x7FF -> 0x000
    cyc("R3", 0,0,1,0,0,'0,0,0,0,0);  // set flip-flop only
    cyc("R4", 0,0,0,1,0,11'h7FF,0,0,0,0);
    cyc("R2", 1,0,0,0,0,'0,0,0,0,0);  // 0xFFF -> 0x800
  endtask

  task automatic t_bank_select();
    cyc("R3", 0,1,1,0,0,'0,0,0,0,0);  // both: hold
    cyc("R3", 1,1,0,0,0,'0,0,0,0,0);
    cyc("R3", 0,0,1,0,0,'0,0,0,0,0);
    cyc("R4", 0,1,0,1,0,11'h155,0,0,0,0);  // jump uses old flip-flop
    cyc("R4", 0,0,0,1,0,11'h0AA,0,0,0,0);
  endtask

  task automatic t_call_ret();
    cyc("R3", 0,0,1,0,0,'0,0,0,0,0);
    cyc("R5", 0,0,0,0,1,11'h123,0,0,0,0);  // call into upper bank
    cyc("R2", 1,0,0,0,0,'0,0,0,0,0);
    cyc("R6", 0,1,0,0,0,'0,1,0,0,0);  // return, and clear flip-flop
    cyc("R6", 1,0,0,0,0,'0,0,0,0,0);
  endtask

  task automatic t_irq();
    cyc("R3", 0,0,1,0,0,'0,0,0,0,0);
    cyc("R4", 0,0,0,1,0,11'h321,0,0,0,0);
    cyc("R7", 0,0,0,0,0,'0,0,0,1,1);
    cyc("R8", 0,1,0,0,0,'0,0,0,0,0);
    cyc("R8", 0,0,1,0,0,'0,0,0,0,0);
    cyc("R8", 0,0,0,1,0,11'h555,0,0,0,0);
    cyc("R8", 0,0,0,0,1,11'h600,0,0,0,0);
    cyc("R6", 0,0,0,0,0,'0,1,0,0,0);
    cyc("R9", 0,0,0,0,0,'0,0,1,0,0);
    cyc("R7", 0,0,0,0,0,'0,0,0,1,0);
    cyc("R9", 0,0,0,0,0,'0,0,1,0,0);
  endtask

  task automatic t_priority();
    cyc("R11", 1,0,0,1,0,11'h222,0,0,1,0);
    cyc("R11", 1,0,0,0,0,'0,0,1,0,0);
    cyc("R11", 0,0,0,1,1,11'h444,0,0,0,0);
    cyc("R11", 0,0,0,1,1,11'h111,1,0,0,0);
    cyc("R11", 0,0,0,0,0,'0,0,0,0,0);
  endtask

  task automatic t_stack_wrap();
    for (int i = 0; i < 9; i++) begin
      cyc("R10", 0,0,0,0,1,11'(16*i + 5),0,0,0,0);
      cyc("R10", 1,0,0,0,0,'0,0,0,0,0);
    end
    for (int i = 0; i < 9; i++) cyc("R10", 0,0,0,0,0,'0,1,0,0,0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_step();
    t_bank_select();
    t_call_ret();
    t_irq();
    t_priority();
    t_stack_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule